// File: doc/BRIEF.md
# Sectored Line Directory with Rotating Replacement

This block is the tag side of a fully associative, sectored cache, used as a hit/miss and event-count engine. Each line of the directory covers a group of 4-word sectors. For every line it holds the line base address, a valid flag, and three sector bit vectors: present, dirty and referenced. A stream of fetch and store requests arrives at one per cycle. Each request carries a word address, a store flag and a jump flag. Every resident line is compared with the request in parallel, and the request is then classified as a hit, a sector-only miss or a whole-line miss.

On a whole-line miss, the line under a rotating replacement pointer is taken over. The dirty sectors it held are counted as write-backs. The pointer also steps forward when a hit lands on the line it currently points at, so a line in active use tends not to become the next one replaced. No data is stored and no memory traffic is produced. The results are the per-request class and a set of saturating event counters. A flush empties the directory and keeps the counters. A reset clears both.

Top module: `sector_dir`

## Requirements
- R1: `req_ready_o` is low only in a cycle where `flush_i` is high. Each accepted request (`req_valid_i && req_ready_o` at a rising edge) gives exactly one response, with `resp_valid_o` high in the following cycle. `resp_kind_o` encodes the class as 0 = hit, 1 = sector miss, 2 = line miss.
- R2: For a request address A, the word index is A mod (QUADS*4), the sector number is that index divided by 4, and the line base is A minus the index. Two addresses with the same line base map to the same line.
- R3: A request whose line is resident but whose sector present bit is clear is class 1. It increments the sector-miss counter and sets that present bit. A later request to the same sector is class 0 and adds to no miss counter.
- R4: A hit on the line selected by the replacement pointer moves the pointer forward by one, wrapping to 0 after line NUM_LINES-1. Hits on other lines leave it unchanged.
- R5: A request whose line is not resident is class 2 and increments the line-miss counter. It takes over the line at the replacement pointer, leaves only the requested sector present, and moves the pointer forward by one with wrap.
- R6: When a valid line is taken over, the dirty-write counter grows by the number of that line's dirty sectors. Taking over an invalid line adds nothing.
- R7: A store sets the dirty bit of the addressed sector after the lookup or fill, on hits and misses alike. A fetch never sets a dirty bit.
- R8: While `lru_en_i` is high, a hit sets the referenced bit of the addressed sector. `resp_refd_o` reports that bit as it stood before the access, and is 0 for a line miss. A fill clears all referenced bits, and with `lru_en_i` low no referenced bit is set.
- R9: Every accepted request increments the probe counter. A class 1 or class 2 request with the jump flag set also increments the jump-miss counter.
- R10: A cycle with `flush_i` high leaves every line invalid and the pointer at 0, and keeps the counter values. An active-low reset does the same and also zeroes all counters.
- R11: Every counter is CNT_W bits wide and saturates at all ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all lines and rewind the pointer, counters kept |
| lru_en_i | input | 1 | Enable setting of referenced bits on hits |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_addr_i | input | ADDR_W | Word address of the request |
| req_store_i | input | 1 | 1 = store, 0 = fetch |
| req_jump_i | input | 1 | Request comes from a control transfer |
| resp_valid_o | output | 1 | Classification valid |
| resp_kind_o | output | 2 | 0 hit, 1 sector miss, 2 line miss |
| resp_refd_o | output | 1 | Referenced bit of the addressed sector before the access |
| cnt_probe_o | output | CNT_W | Accepted requests |
| cnt_sector_o | output | CNT_W | Sector-only misses |
| cnt_line_o | output | CNT_W | Whole-line misses |
| cnt_jump_o | output | CNT_W | Misses on jump requests |
| cnt_dirty_o | output | CNT_W | Dirty sectors discarded on takeover |

## Verification
The embedded checks assume that flush and requests never overlap. Because the block drops ready during a flush, a request in that cycle is not taken. They also assume that at most one resident line matches any address, which holds only if every line enters the directory through a line miss. The stimulus presents each request in a single cycle with `lru_en_i`, `req_store_i` and `req_jump_i` held alongside it. It asserts flush only while no request is offered. Addresses are kept to a small window, so that hits, sector misses, rotations past the pointer, dirty takeovers and counter saturation all occur.

// File: rtl/sdir_pkg.sv
package sdir_pkg;
   localparam int unsigned QMAX = 8;          // sector bit vectors sized for the largest line
   typedef logic [QMAX-1:0] qvec_t;

   localparam logic [1:0] KIND_HIT    = 2'd0;
   localparam logic [1:0] KIND_SECTOR = 2'd1;
   localparam logic [1:0] KIND_LINE   = 2'd2;

   localparam int unsigned NUM_CNT    = 5;
   localparam int unsigned CNT_PROBE  = 0;
   localparam int unsigned CNT_SECTOR = 1;
   localparam int unsigned CNT_LINE   = 2;
   localparam int unsigned CNT_JUMP   = 3;
   localparam int unsigned CNT_DIRTY  = 4;
endpackage

// File: rtl/sdir_addr_split.sv
module sdir_addr_split #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned QUADS  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] line_base,
   output logic [2:0]        quad
);
   localparam int unsigned WPL = QUADS * 4;
   localparam bit          POW2 = (WPL & (WPL - 1)) == 0;

   logic [ADDR_W-1:0] word_idx;

   generate
      if (POW2) begin : g_mask
         assign word_idx = addr & ADDR_W'(WPL - 1);
      end else begin : g_mod
         assign word_idx = addr % ADDR_W'(WPL);
      end
   endgenerate

   assign line_base = addr - word_idx;
   assign quad      = 3'(word_idx >> 2);

   always_comb begin
      assert (word_idx < ADDR_W'(WPL)) else $error("AST_INDEX_RANGE"); // R2
   end
endmodule

// File: rtl/sdir_entry.sv
module sdir_entry
   import sdir_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [ADDR_W-1:0] line_base,
   input  qvec_t             quad_oh,
   input  logic              hit_we,
   input  logic              fill_we,
   input  logic              is_store,
   input  logic              lru_en,
   output logic              match,
   output qvec_t             present,
   output qvec_t             dirty,
   output qvec_t             refd
);
   logic              valid;
   logic [ADDR_W-1:0] tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         tag     <= '0;
         present <= '0;
         dirty   <= '0;
         refd    <= '0;
      end else if (flush) begin
         valid   <= 1'b0;
         tag     <= '0;
         present <= '0;
         dirty   <= '0;
         refd    <= '0;
      end else if (fill_we) begin
         valid   <= 1'b1;
         tag     <= line_base;
         present <= quad_oh;
         dirty   <= is_store ? quad_oh : '0;
         refd    <= '0;
      end else if (hit_we) begin
         present <= present | quad_oh;
         if (is_store) dirty <= dirty | quad_oh;
         if (lru_en)   refd  <= refd | quad_oh;
      end
   end

   assign match = valid && (tag == line_base);

   AST_FILL_ONE_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
      fill_we |=> $onehot(present)); // R5
   AST_FETCH_KEEPS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_we && !is_store && !flush) |=> $stable(dirty)); // R7
   AST_REF_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_we && !lru_en && !flush) |=> $stable(refd)); // R8
endmodule

// File: rtl/sdir_victim.sv
module sdir_victim #(
   parameter int unsigned NUM_LINES = 8,
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

   generate
      if (NUM_LINES == (1 << IDX_W)) begin : g_natural_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (flush) ptr <= '0;
            else if (adv)   ptr <= ptr + 1'b1;
         end
      end else begin : g_compare_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ptr <= '0;
            else if (flush) ptr <= '0;
            else if (adv)   ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
         end
      end
   endgenerate

   AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST); // R4
   AST_FLUSH_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> ptr == '0); // R10
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !flush) |=> $stable(ptr)); // R4
endmodule

// File: rtl/sdir_stats.sv
module sdir_stats
   import sdir_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_CNT-1:0][3:0]         inc,
   output logic [NUM_CNT-1:0][CNT_W-1:0]   counts
);
   for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
      logic [CNT_W:0] sum;
      assign sum = {1'b0, counts[g]} + (CNT_W + 1)'(inc[g]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) counts[g] <= '0;
         else        counts[g] <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
      end

      AST_CNT_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> counts[g] >= $past(counts[g])); // R11
      AST_CNT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
         (counts[g] == '1) |=> (counts[g] == '1)); // R11
   end
endmodule

// File: rtl/sector_dir.sv
module sector_dir
   import sdir_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned NUM_LINES = 8,
   parameter int unsigned QUADS     = 2,
   parameter int unsigned CNT_W     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              lru_en_i,
   input  logic              req_valid_i,
   output logic              req_ready_o,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic              req_store_i,
   input  logic              req_jump_i,
   output logic              resp_valid_o,
   output logic [1:0]        resp_kind_o,
   output logic              resp_refd_o,
   output logic [CNT_W-1:0]  cnt_probe_o,
   output logic [CNT_W-1:0]  cnt_sector_o,
   output logic [CNT_W-1:0]  cnt_line_o,
   output logic [CNT_W-1:0]  cnt_jump_o,
   output logic [CNT_W-1:0]  cnt_dirty_o
);
   localparam int unsigned IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;

   generate
      if (NUM_LINES < 1)            begin : g_bad_lines $error("NUM_LINES must be at least 1"); end
      if (QUADS < 1 || QUADS > 7)   begin : g_bad_quads $error("QUADS must lie in 1..7"); end
      if (ADDR_W < 8)               begin : g_bad_addr  $error("ADDR_W must be at least 8"); end
      if (CNT_W < 4)                begin : g_bad_cnt   $error("CNT_W must be at least 4"); end
   endgenerate

   logic              accept;
   logic [ADDR_W-1:0] line_base;
   logic [2:0]        quad;
   qvec_t             quad_oh;
   logic [NUM_LINES-1:0] match_vec, hit_we, fill_we;
   qvec_t             present_arr [NUM_LINES];
   qvec_t             dirty_arr   [NUM_LINES];
   qvec_t             ref_arr     [NUM_LINES];
   qvec_t             sel_present, sel_ref;
   logic              any_hit, quad_present, quad_ref;
   logic [1:0]        kind;
   logic [IDX_W-1:0]  vptr;
   logic              adv;
   logic [3:0]        victim_dirty;
   logic [NUM_CNT-1:0][3:0]       inc;
   logic [NUM_CNT-1:0][CNT_W-1:0] counts;

   assign req_ready_o = !flush_i;
   assign accept      = req_valid_i && req_ready_o;

   sdir_addr_split #(.ADDR_W(ADDR_W), .QUADS(QUADS)) u_split (
      .addr      (req_addr_i),
      .line_base (line_base),
      .quad      (quad)
   );

   assign quad_oh = qvec_t'(1) << quad;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      assign hit_we[g]  = accept && match_vec[g];
      assign fill_we[g] = accept && !any_hit && (vptr == IDX_W'(g));

      sdir_entry #(.ADDR_W(ADDR_W)) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (flush_i),
         .line_base (line_base),
         .quad_oh   (quad_oh),
         .hit_we    (hit_we[g]),
         .fill_we   (fill_we[g]),
         .is_store  (req_store_i),
         .lru_en    (lru_en_i),
         .match     (match_vec[g]),
         .present   (present_arr[g]),
         .dirty     (dirty_arr[g]),
         .refd      (ref_arr[g])
      );
   end

   always_comb begin
      sel_present = '0;
      sel_ref     = '0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (match_vec[i]) begin
            sel_present = sel_present | present_arr[i];
            sel_ref     = sel_ref | ref_arr[i];
         end
      end
   end

   assign any_hit      = |match_vec;
   assign quad_present = |(sel_present & quad_oh);
   assign quad_ref     = |(sel_ref & quad_oh);
   assign kind         = !any_hit ? KIND_LINE : (quad_present ? KIND_HIT : KIND_SECTOR);

   // pointer moves on every takeover and on a hit to the pointed line
   assign adv = accept && (!any_hit || match_vec[vptr]);

   sdir_victim #(.NUM_LINES(NUM_LINES)) u_victim (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush_i),
      .adv   (adv),
      .ptr   (vptr)
   );

   assign victim_dirty = 4'($countones(dirty_arr[vptr]));

   always_comb begin
      inc             = '0;
      inc[CNT_PROBE]  = {3'b0, accept};
      inc[CNT_SECTOR] = {3'b0, accept && (kind == KIND_SECTOR)};
      inc[CNT_LINE]   = {3'b0, accept && (kind == KIND_LINE)};
      inc[CNT_JUMP]   = {3'b0, accept && (kind != KIND_HIT) && req_jump_i};
      inc[CNT_DIRTY]  = (accept && (kind == KIND_LINE)) ? victim_dirty : 4'd0;
   end

   sdir_stats #(.CNT_W(CNT_W)) u_stats (
      .clk    (clk),
      .rst_n  (rst_n),
      .inc    (inc),
      .counts (counts)
   );

   assign cnt_probe_o  = counts[CNT_PROBE];
   assign cnt_sector_o = counts[CNT_SECTOR];
   assign cnt_line_o   = counts[CNT_LINE];
   assign cnt_jump_o   = counts[CNT_JUMP];
   assign cnt_dirty_o  = counts[CNT_DIRTY];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid_o <= 1'b0;
         resp_kind_o  <= KIND_HIT;
         resp_refd_o  <= 1'b0;
      end else begin
         resp_valid_o <= accept;
         if (accept) begin
            resp_kind_o <= kind;
            resp_refd_o <= any_hit && quad_ref;
         end
      end
   end

   AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec)); // R2
   AST_RESP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> resp_valid_o); // R1
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (match_vec == '0)); // R10
   AST_REFD_ON_HIT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid_o && resp_refd_o) |-> (resp_kind_o != KIND_LINE)); // R8
   AST_PROBE_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (cnt_probe_o != '1)) |=> (cnt_probe_o != $past(cnt_probe_o))); // R9

   generate
      if (NUM_LINES > 1) begin : g_move_chk
         AST_TAKEOVER_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && (kind == KIND_LINE)) |=> !$stable(vptr)); // R5
      end
   endgenerate
endmodule

// File: tb/test_sector_dir.sv
module test_sector_dir;
   localparam int N   = 4;
   localparam int Q   = 2;
   localparam int CW  = 8;
   localparam int AW  = 32;
   localparam int WPL = Q * 4;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n = 1'b0, flush = 1'b0, lru_en = 1'b0;
   logic req_valid = 1'b0, req_store = 1'b0, req_jump = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic req_ready, resp_valid, resp_refd;
   logic [1:0] resp_kind;
   logic [CW-1:0] c_probe, c_sector, c_line, c_jump, c_dirty;

   sector_dir #(.ADDR_W(AW), .NUM_LINES(N), .QUADS(Q), .CNT_W(CW)) i_sector_dir (
      .clk(clk), .rst_n(rst_n), .flush_i(flush), .lru_en_i(lru_en),
      .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
      .req_store_i(req_store), .req_jump_i(req_jump),
      .resp_valid_o(resp_valid), .resp_kind_o(resp_kind), .resp_refd_o(resp_refd),
      .cnt_probe_o(c_probe), .cnt_sector_o(c_sector), .cnt_line_o(c_line),
      .cnt_jump_o(c_jump), .cnt_dirty_o(c_dirty)
   );

   int errors = 0;
   int checks = 0;

   // expected-state model built from the requirements
   logic [AW-1:0] m_tag [N];
   bit            m_val [N];
   logic [7:0]    m_pres [N], m_dirty [N], m_ref [N];
   int            m_ptr;
   int            m_cnt [5];

   typedef struct {
      logic [1:0] kind;
      logic       refd;
      string      req;
   } exp_t;
   exp_t sb [$];

   task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic void bump(input int id, input int amt);
      m_cnt[id] = (m_cnt[id] + amt > CMAX) ? CMAX : m_cnt[id] + amt;
   endfunction

   function automatic void model_empty(input bit zero_counters);
      for (int i = 0; i < N; i++) begin
         m_val[i] = 0; m_tag[i] = '0; m_pres[i] = '0; m_dirty[i] = '0; m_ref[i] = '0;
      end
      m_ptr = 0;
      if (zero_counters) for (int i = 0; i < 5; i++) m_cnt[i] = 0;
   endfunction

   // driver: predicts the outcome, queues it, presents the request for one cycle
   task automatic req(input logic [AW-1:0] a, input bit st, input bit jp, input bit lru, input string tag);
      exp_t e;
      int idx, qd, h;
      logic [AW-1:0] base;
      logic [7:0] qb;
      idx  = int'(a % WPL);
      qd   = idx / 4;
      base = a - AW'(idx);
      qb   = 8'(1) << qd;
      h    = -1;
      for (int i = 0; i < N; i++) if (m_val[i] && m_tag[i] == base) h = i;
      if (h >= 0) begin
         e.refd = |(m_ref[h] & qb);
         if ((m_pres[h] & qb) != 0) e.kind = 2'd0;
         else begin e.kind = 2'd1; bump(1, 1); end
         m_pres[h] |= qb;
         if (lru) m_ref[h] |= qb;
         if (st)  m_dirty[h] |= qb;
         if (h == m_ptr) m_ptr = (m_ptr + 1) % N;
      end else begin
         e.kind = 2'd2;
         e.refd = 1'b0;
         if (m_val[m_ptr]) bump(4, $countones(m_dirty[m_ptr]));
         m_val[m_ptr]   = 1;
         m_tag[m_ptr]   = base;
         m_pres[m_ptr]  = qb;
         m_dirty[m_ptr] = st ? qb : 8'h0;
         m_ref[m_ptr]   = '0;
         bump(2, 1);
         m_ptr = (m_ptr + 1) % N;
      end
      bump(0, 1);
      if (e.kind != 2'd0 && jp) bump(3, 1);
      e.req = tag;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_store = st; req_jump = jp; lru_en = lru;
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0; req_store = 1'b0; req_jump = 1'b0;
   endtask

   task automatic check_counters(input string ctx);
      check("R9",  {ctx, " probe count"},      64'(c_probe),  64'(m_cnt[0]));
      check("R3",  {ctx, " sector-miss count"}, 64'(c_sector), 64'(m_cnt[1]));
      check("R5",  {ctx, " line-miss count"},   64'(c_line),   64'(m_cnt[2]));
      check("R9",  {ctx, " jump-miss count"},   64'(c_jump),   64'(m_cnt[3]));
      check("R6",  {ctx, " dirty-write count"}, 64'(c_dirty),  64'(m_cnt[4]));
   endtask

   task automatic do_flush();
      @(negedge clk);
      req_valid = 1'b0;
      flush = 1'b1;
      #1 check("R1", "ready during flush", 64'(req_ready), 64'd0);
      @(negedge clk);
      flush = 1'b0;
      model_empty(0);
   endtask

   // monitor: pops the scoreboard as responses appear
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && resp_valid) begin
         if (sb.size() == 0) check("R1", "unexpected response", 64'd1, 64'd0);
         else begin
            e = sb.pop_front();
            check(e.req, "response class", 64'(resp_kind), 64'(e.kind));
            check("R8", {e.req, " referenced flag"}, 64'(resp_refd), 64'(e.refd));
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      model_empty(1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      check("R10", "resp_valid after reset", 64'(resp_valid), 64'd0);
      check("R1", "ready when idle", 64'(req_ready), 64'd1);
      check_counters("R10 reset");

      // R2/R3/R5: address split, sector fills
      req(32'h100, 0, 1, 0, "R5 cold miss");
      req(32'h101, 0, 0, 0, "R2 same sector hit");
      req(32'h104, 0, 1, 0, "R3 sector miss");
      req(32'h107, 0, 0, 0, "R3 sector now present");
      idle();
      check_counters("R3 sectors");

      // R4/R6/R7: fill all lines, hit on pointer, dirty takeover
      req(32'h200, 1, 0, 0, "R7 store fill");
      req(32'h300, 0, 0, 0, "R5 fill");
      req(32'h400, 0, 0, 0, "R5 fill");
      req(32'h100, 0, 0, 0, "R4 hit on pointer");
      req(32'h500, 0, 0, 0, "R6 takeover dirty line");
      idle();
      check("R6", "one dirty sector written", 64'(c_dirty), 64'd1);
      req(32'h200, 0, 1, 0, "R5 evicted line misses");
      req(32'h100, 0, 0, 0, "R4 pointer skipped hit line");
      idle();
      check_counters("R4 rotation");

      // R8: referenced bits
      req(32'h100, 0, 0, 1, "R8 hit sets ref");
      req(32'h101, 0, 0, 1, "R8 ref reported");
      req(32'h500, 0, 0, 0, "R8 no ref when off");
      req(32'h500, 0, 0, 0, "R8 still clear");
      idle();

      // R7: two dirty sectors on one line, then fetch-only line
      req(32'h600, 1, 0, 0, "R7 store miss");
      req(32'h604, 1, 1, 0, "R7 store sector miss");
      for (int i = 0; i < N; i++) req(32'h1000 + 32'(i * WPL), 0, 0, 0, "R6 sweep");
      idle();
      check_counters("R7 dirty sweep");

      // R10: flush keeps counters and empties lines
      do_flush();
      check_counters("R10 after flush");
      req(32'h1000, 0, 1, 0, "R10 miss after flush");
      req(32'h1000, 1, 0, 0, "R10 refill hit");
      idle();
      check_counters("R10 post flush");

      // mixed traffic
      lfsr = 16'hACE1;
      for (int i = 0; i < 150; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         req(AW'(lfsr & 16'h003F), lfsr[7], lfsr[9], lfsr[3], "R2 mixed");
         if (i == 70) begin idle(); do_flush(); end
      end
      idle();
      check_counters("R9 mixed");

      // R11: saturation
      for (int i = 0; i < 300; i++) req(AW'(i * 4), 0, 1, 0, "R11 flood");
      idle();
      check("R11", "probe saturates", 64'(c_probe), 64'(CMAX));
      check_counters("R11 saturation");

      // R10: reset clears counters
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      model_empty(1);
      sb.delete();
      @(negedge clk);
      check_counters("R10 second reset");
      req(32'h100, 0, 0, 0, "R10 empty after reset");
      idle();
      @(negedge clk);
      check("R1", "scoreboard drained", 64'(sb.size()), 64'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule